// File: doc/BRIEF.md
# Oscillation stop detection controller

This block watches a main-clock oscillator from a free-running reference clock. The main clock arrives as an ordinary data input. It passes through a two-flop synchronizer, and its rising edges are counted in fixed windows of reference cycles. A window with no edge means the oscillator has stopped. A run of consecutive windows that each hold an edge means it has started again. Both events feed one 8-bit control and status register.

Software reaches the register through a small register bus. Writes land only while the protect-enable input is high. An event sets a sticky event flag. Depending on the action-select bit, it also raises a one-cycle interrupt pulse or a one-cycle reset-request pulse. When the oscillator stops while the CPU runs straight from the main clock (not from the PLL), the block moves the clock-source selection over to the on-chip oscillator by itself. A live monitor bit reports whether the main clock is currently oscillating.

A reset that the system raised because of this block's own reset request is flagged on `osc_rst_i`. Such a reset keeps the enable, clock-source and action-select bits. Any other reset restores all defaults.

Top module: `osc_guard`

## Requirements
- R1: After an ordinary reset (`rst_n` low with `osc_rst_i` low), reading address `REG_ADDR` (default 4'hC) returns 8'h02. Reading any other address returns 8'h00.
- R2: The register layout is as follows, and the unlisted bits always read 0:
  - bit 0: detection enable (read/write);
  - bit 1: clock-source select (0 = main or PLL, 1 = on-chip oscillator), which also drives `osc_sel_o`;
  - bit 2: event flag;
  - bit 3: read-only monitor (1 = main clock not oscillating);
  - bit 7: action select (0 = reset request, 1 = interrupt).
- R3: A write while `prot_en_i` is 0 changes no register bit.
- R4: While `clk_lock_i` is 1, a write leaves the enable bit unchanged. Other bits are written as usual.
- R5: A stop is recognised when a window of `WIN_CYC` (16) reference cycles contains no synchronized rising edge while the clock was running. The monitor bit then reads 1. If the enable bit is 1, the event flag is set.
- R6: A restart is recognised after `RESTART_N` (4) consecutive windows that each contain an edge while the clock was stopped. The monitor bit then reads 0. If the enable bit is 1, the event flag is set.
- R7: `irq_o` is a one-cycle pulse. It is issued only when an enabled event with action select 1 takes the event flag from 0 to 1.
- R8: An event that arrives while the event flag is already 1 produces no interrupt pulse.
- R9: Writing 0 to bit 2 clears the event flag. Writing 1 to bit 2 leaves it unchanged.
- R10: An enabled stop with action select 1 and `pll_sel_i` = 0 sets the clock-source bit to 1. With `pll_sel_i` = 1 the bit is left unchanged.
- R11: While the enable bit is 1 and the monitor bit is 1, a write of 0 to the clock-source bit is ignored.
- R12: An enabled stop with action select 0 produces a one-cycle `rst_req_o` pulse and no interrupt pulse.
- R13: A reset with `osc_rst_i` = 1 keeps the enable, clock-source and action-select bits, and clears the event flag.
- R14: With the enable bit 0, stops and restarts set no flag and raise no pulse. The monitor bit still follows the oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_rst_i | input | 1 | The current reset was caused by this block's reset request |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| prot_en_i | input | 1 | Write permission for the register |
| clk_lock_i | input | 1 | Locks the detection-enable bit |
| pll_sel_i | input | 1 | CPU clock currently taken from the PLL |
| main_clk_i | input | 1 | Main clock sampled as data |
| irq_o | output | 1 | Interrupt request pulse |
| rst_req_o | output | 1 | Reset request pulse |
| osc_sel_o | output | 1 | Clock-source select, 1 = on-chip oscillator |

## Verification
Writes are visible on `bus_rdata` one reference cycle after the write edge, so the bench reads back on the following falling edge. Detection latency depends on the window phase and the synchronizer delay. A stop is reported within about two windows plus three cycles, and a restart within about `RESTART_N` + 2 windows. The bench therefore waits 60 and 120 cycles, which clears both bounds. Over each wait it counts `irq_o` and `rst_req_o` pulses, then compares the pulse counts and the register value with its own model. Random writes under random protect and lock settings run while the main clock toggles steadily, so the expected value follows from the write rules alone.

// File: rtl/osc_guard_pkg.sv
// Package: shared bit positions and defaults of the oscillation guard register.
// Assumes an 8-bit register. Positions are fixed because software decodes them.
package osc_guard_pkg;
    localparam int REG_W   = 8;
    localparam int B_EN    = 0;
    localparam int B_SEL   = 1;
    localparam int B_FLAG  = 2;
    localparam int B_MON   = 3;
    localparam int B_ACT   = 7;

    typedef struct packed {
        logic act;
        logic flag;
        logic sel;
        logic en;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{act: 1'b0, flag: 1'b0, sel: 1'b1, en: 1'b0};
endpackage

// File: rtl/osc_guard_sync.sv
// Module: brings the sampled main clock into the reference domain and marks rising edges.
// Assumes the main clock toggles no faster than half the reference rate.
// SYNC_N flops form the synchronizer. One more flop gives the edge.
module osc_guard_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_clk_i,
    output logic rise_o
);
    logic [SYNC_N-1:0] chain_q;
    logic              last_q;

    // Shift the raw sample through the synchronizer chain and keep the previous output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_N-2:0], main_clk_i};
            last_q  <= chain_q[SYNC_N-1];
        end
    end

    assign rise_o = chain_q[SYNC_N-1] & ~last_q;
endmodule

// File: rtl/osc_guard_detect.sv
// Module: window-based stop and restart detector.
// Assumes the main clock is running at reset.
// Each window of WIN_CYC cycles records whether any edge was seen.
// An empty window stops a running clock. RESTART_N full windows in a row restart a stopped one.
module osc_guard_detect #(
    parameter int WIN_CYC   = 16,
    parameter int RESTART_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic stop_ev_o,
    output logic restart_ev_o,
    output logic mon_o
);
    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int GW = $clog2(RESTART_N + 1);
    localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_CYC - 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(RESTART_N - 1);

    logic [CW-1:0] cnt_q;
    logic [GW-1:0] good_q;
    logic          seen_q;
    logic          run_q;
    logic          win_has_edge;

    assign win_has_edge = seen_q | rise_i;

    // Advance the window, judge it at its last cycle and emit event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            good_q       <= '0;
            seen_q       <= 1'b0;
            run_q        <= 1'b1;
            stop_ev_o    <= 1'b0;
            restart_ev_o <= 1'b0;
        end else begin
            stop_ev_o    <= 1'b0;
            restart_ev_o <= 1'b0;
            if (cnt_q == WIN_LAST) begin
                cnt_q  <= '0;
                seen_q <= 1'b0;
                if (win_has_edge) begin
                    if (!run_q) begin
                        if (good_q == GOOD_LAST) begin
                            run_q        <= 1'b1;
                            restart_ev_o <= 1'b1;
                            good_q       <= '0;
                        end else begin
                            good_q <= good_q + 1'b1;
                        end
                    end
                end else begin
                    good_q <= '0;
                    if (run_q) begin
                        run_q     <= 1'b0;
                        stop_ev_o <= 1'b1;
                    end
                end
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                seen_q <= win_has_edge;
            end
        end
    end

    assign mon_o = ~run_q;

    assert_stop_sets_mon_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev_o |-> mon_o && !restart_ev_o);
    assert_restart_clears_mon_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_ev_o |-> !mon_o);
    assert_events_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev_o || restart_ev_o) |=> !(stop_ev_o || restart_ev_o));
endmodule

// File: rtl/osc_guard_regs.sv
// Module: control/status register with event flag, clock-source override and request pulses.
// Assumes the write strobe is already qualified by address and protect-enable.
// A reset marked as oscillation-caused keeps enable, source and action.
module osc_guard_regs
    import osc_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_rst_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             clk_lock_i,
    input  logic             pll_sel_i,
    input  logic             stop_ev_i,
    input  logic             restart_ev_i,
    input  logic             mon_i,
    output ctrl_t            ctrl_o,
    output logic             irq_o,
    output logic             rst_req_o
);
    ctrl_t ctrl_q;
    logic  ev_hit;
    logic  auto_sw;
    logic  sel_wr_ok;

    assign ev_hit    = ctrl_q.en & (stop_ev_i | restart_ev_i);
    assign auto_sw   = ctrl_q.en & ctrl_q.act & ~pll_sel_i & stop_ev_i;
    assign sel_wr_ok = wdata_i[B_SEL] | ~(ctrl_q.en & mon_i);

    // Update register fields from writes and detector events. Events take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.flag <= 1'b0;
            if (!osc_rst_i) begin
                ctrl_q.en  <= CTRL_DEFAULT.en;
                ctrl_q.sel <= CTRL_DEFAULT.sel;
                ctrl_q.act <= CTRL_DEFAULT.act;
            end
        end else begin
            if (wr_i && !clk_lock_i) ctrl_q.en <= wdata_i[B_EN];
            if (wr_i) ctrl_q.act <= wdata_i[B_ACT];
            if (auto_sw) ctrl_q.sel <= 1'b1;
            else if (wr_i && sel_wr_ok) ctrl_q.sel <= wdata_i[B_SEL];
            if (ev_hit) ctrl_q.flag <= 1'b1;
            else if (wr_i && !wdata_i[B_FLAG]) ctrl_q.flag <= 1'b0;
        end
    end

    // Issue one-cycle request pulses on qualifying events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            irq_o     <= ev_hit & ctrl_q.act & ~ctrl_q.flag;
            rst_req_o <= ctrl_q.en & ~ctrl_q.act & stop_ev_i;
        end
    end

    assign ctrl_o = ctrl_q;

    assert_irq_on_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl_q.flag && !$past(ctrl_q.flag));
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    assert_rstreq_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    assert_lock_holds_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lock_i |=> $stable(ctrl_q.en));
    assert_flag_write1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[B_FLAG] && !ctrl_q.flag && !stop_ev_i && !restart_ev_i) |=> !ctrl_q.flag);
    assert_pll_keeps_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev_i && pll_sel_i && !wr_i) |=> $stable(ctrl_q.sel));
    assert_idle_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !stop_ev_i) |=> $stable({ctrl_q.en, ctrl_q.act, ctrl_q.sel}));
endmodule

// File: rtl/osc_guard.sv
// Module: top of the oscillation stop detection controller.
// Assumes a single register at REG_ADDR and combinational read data.
// Composes the synchronizer, the window detector and the register.
module osc_guard
    import osc_guard_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'hC,
    parameter int              SYNC_N    = 2,
    parameter int              WIN_CYC   = 16,
    parameter int              RESTART_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_rst_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              prot_en_i,
    input  logic              clk_lock_i,
    input  logic              pll_sel_i,
    input  logic              main_clk_i,
    output logic              irq_o,
    output logic              rst_req_o,
    output logic              osc_sel_o
);
    logic  rise;
    logic  stop_ev;
    logic  restart_ev;
    logic  mon;
    logic  addr_hit;
    logic  wr;
    ctrl_t ctrl;

    assign addr_hit = (bus_addr == REG_ADDR);
    assign wr       = bus_we & addr_hit & prot_en_i;

    osc_guard_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .main_clk_i(main_clk_i), .rise_o(rise)
    );

    osc_guard_detect #(.WIN_CYC(WIN_CYC), .RESTART_N(RESTART_N)) u_det (
        .clk(clk), .rst_n(rst_n), .rise_i(rise),
        .stop_ev_o(stop_ev), .restart_ev_o(restart_ev), .mon_o(mon)
    );

    osc_guard_regs u_regs (
        .clk(clk), .rst_n(rst_n), .osc_rst_i(osc_rst_i),
        .wr_i(wr), .wdata_i(bus_wdata), .clk_lock_i(clk_lock_i),
        .pll_sel_i(pll_sel_i), .stop_ev_i(stop_ev), .restart_ev_i(restart_ev),
        .mon_i(mon), .ctrl_o(ctrl), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    // Assemble read data. Unassigned and reserved bits read 0.
    always_comb begin
        bus_rdata = '0;
        if (addr_hit) begin
            bus_rdata[B_EN]   = ctrl.en;
            bus_rdata[B_SEL]  = ctrl.sel;
            bus_rdata[B_FLAG] = ctrl.flag;
            bus_rdata[B_MON]  = mon;
            bus_rdata[B_ACT]  = ctrl.act;
        end
    end

    assign osc_sel_o = ctrl.sel;

    assert_sel_pin_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> (osc_sel_o == bus_rdata[B_SEL]) && (bus_rdata[6:4] == 3'b000));
    assert_prot_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_en_i && !stop_ev) |=> $stable({ctrl.en, ctrl.act, ctrl.sel}));
endmodule

// File: tb/osc_guard_tb_top.sv
module osc_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_rst = 1'b0;
    logic [3:0] addr = 4'hC;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       prot = 1'b1;
    logic       lock = 1'b0;
    logic       pll = 1'b0;
    logic       main_clk = 1'b0;
    logic       main_run = 1'b1;
    logic       irq, rstreq, sel_pin;

    int checks = 0, fails = 0, irq_cnt = 0, rst_cnt = 0;
    int div = 0;
    bit done = 0;
    bit m_en, m_sel, m_flag, m_mon, m_act;

    always #2 clk = ~clk;

    osc_guard dut_i (
        .clk(clk), .rst_n(rst_n), .osc_rst_i(osc_rst), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .prot_en_i(prot), .clk_lock_i(lock),
        .pll_sel_i(pll), .main_clk_i(main_clk), .irq_o(irq), .rst_req_o(rstreq),
        .osc_sel_o(sel_pin)
    );

    // Main clock model: toggles every 3 reference cycles while running.
    always @(negedge clk) begin
        if (main_run) begin
            if (div == 2) begin main_clk <= ~main_clk; div <= 0; end
            else div <= div + 1;
        end
    end

    // Pulse counters.
    always @(posedge clk) begin
        if (irq) irq_cnt <= irq_cnt + 1;
        if (rstreq) rst_cnt <= rst_cnt + 1;
    end

    function automatic logic [7:0] exp_reg();
        return {m_act, 3'b000, m_mon, m_flag, m_sel, m_en};
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        addr = 4'hC; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
        if (prot) begin
            if (!lock) m_en = d[0];
            if (d[1] || !(m_en_prev_blocks())) m_sel = d[1];
            if (!d[2]) m_flag = 1'b0;
            m_act = d[7];
        end
    endtask

    // Holds the enable value from before the write, for the source-clear rule.
    bit en_before;
    function automatic bit m_en_prev_blocks();
        return en_before && m_mon;
    endfunction

    task automatic wrm(logic [7:0] d);
        en_before = m_en;
        wr(d);
    endtask

    task automatic do_reset(bit osc);
        @(negedge clk);
        rst_n = 1'b0; osc_rst = osc;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; osc_rst = 1'b0;
        m_flag = 0; m_mon = 0;
        if (!osc) begin m_en = 0; m_sel = 1; m_act = 0; end
        @(negedge clk);
    endtask

    task automatic read_chk(string tag);
        addr = 4'hC;
        @(negedge clk);
        check(tag, rdata, exp_reg());
        check({tag, " pin"}, sel_pin, m_sel);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int i0, r0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        do_reset(0);
        read_chk("R1 reset value");
        addr = 4'h3; @(negedge clk);
        check("R1 other address", rdata, 0);

        // Random writes under random protect/lock (R2, R3, R4).
        for (int k = 0; k < 200; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            prot = ($urandom % 4) != 0;
            lock = ($urandom % 3) == 0;
            wrm(d);
            read_chk(!prot ? "R3 protected write" : (lock ? "R4 locked enable" : "R2 readback"));
        end
        prot = 1; lock = 0;

        // Stop with interrupt action on main clock (R5, R7, R10).
        wrm(8'h81); read_chk("R2 setup");
        i0 = irq_cnt; r0 = rst_cnt;
        main_run = 0; repeat (60) @(negedge clk);
        m_mon = 1; m_flag = 1; m_sel = 1;
        read_chk("R5 R10 stop auto switch");
        check("R7 irq on stop", irq_cnt - i0, 1);
        check("R12 no reset req in irq mode", rst_cnt - r0, 0);

        // Restart while flag already set (R6, R8).
        i0 = irq_cnt;
        main_run = 1; repeat (120) @(negedge clk);
        m_mon = 0;
        read_chk("R6 restart");
        check("R8 no irq when flag set", irq_cnt - i0, 0);

        // Flag write rules (R9).
        wrm(8'h87); read_chk("R9 write 1 keeps flag");
        wrm(8'h83); read_chk("R9 write 0 clears flag");
        wrm(8'h81); read_chk("R11 clear sel allowed when running");

        // Stop under PLL (R10).
        pll = 1; i0 = irq_cnt;
        main_run = 0; repeat (60) @(negedge clk);
        m_mon = 1; m_flag = 1;
        read_chk("R10 pll keeps sel");
        check("R7 irq under pll", irq_cnt - i0, 1);

        // Source clear blocked while stopped (R11).
        wrm(8'h83); read_chk("R11 set sel");
        wrm(8'h81); read_chk("R11 clear blocked");

        // Restart sets flag from 0 (R6, R7).
        pll = 0; i0 = irq_cnt;
        main_run = 1; repeat (120) @(negedge clk);
        m_mon = 0; m_flag = 1;
        read_chk("R6 restart flag");
        check("R7 irq on restart", irq_cnt - i0, 1);

        // Reset-request action (R12).
        wrm(8'h01); read_chk("R12 setup");
        i0 = irq_cnt; r0 = rst_cnt;
        main_run = 0; repeat (60) @(negedge clk);
        m_mon = 1; m_flag = 1;
        read_chk("R12 no auto switch");
        check("R12 reset req", rst_cnt - r0, 1);
        check("R12 no irq", irq_cnt - i0, 0);
        main_run = 1; repeat (120) @(negedge clk);
        m_mon = 0;
        read_chk("R6 restart in reset mode");

        // Oscillation-caused reset retains bits (R13).
        do_reset(1); read_chk("R13 retain after osc reset");
        wrm(8'h83); do_reset(1); read_chk("R13 retain 83");
        do_reset(0); read_chk("R1 ordinary reset");

        // Disabled detection (R14).
        wrm(8'h80); read_chk("R14 setup");
        i0 = irq_cnt; r0 = rst_cnt;
        main_run = 0; repeat (60) @(negedge clk);
        m_mon = 1;
        read_chk("R14 stop while disabled");
        check("R14 no irq", irq_cnt - i0, 0);
        main_run = 1; repeat (120) @(negedge clk);
        m_mon = 0;
        read_chk("R14 restart while disabled");
        check("R14 no pulses", (irq_cnt - i0) + (rst_cnt - r0), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule